// File: doc/BRIEF.md
# Setup Packet Receive Buffer

This block holds one eight-byte control setup packet. The USB side writes it and the CPU side reads it. The USB side frames each packet with a start strobe, a run of byte-valid cycles and an end strobe. The CPU side pulls bytes one at a time through a single read port. It also sees three flags: a packet-accepted flag, a packet-error flag and a sticky read-invalid flag.

The USB side always wins. A new reception overwrites the storage even while the CPU is part-way through reading the previous packet. Any CPU read that overlaps a reception is flagged as invalid. The CPU read position advances modulo eight and is never realigned by a new packet. Software that stops a read sequence early therefore reads the next packet starting at the wrong byte.

Top module: `setup_pkt_buf`

## Requirements
- R1: Bytes accepted during a reception are stored at slots 0 to 7 in arrival order. Reading eight times from read position 0 returns them in that order.
- R2: A `cpu_rd` pulse loads `cpu_rdata` on the next cycle with the byte at the current read position. The position then advances by one modulo 8. A new packet does not reset it.
- R3: When a USB byte write and a CPU read hit the same cycle, the write always completes. The read returns the slot contents from before that write.
- R4: `usb_start` opens a reception, sets the write slot to 0 and clears both `setup_rcvd` and `pkt_err`. `usb_valid` in the start cycle is ignored.
- R5: An `usb_end` that closes a reception after exactly 8 accepted bytes sets `setup_rcvd` one cycle later and leaves `pkt_err` at 0. A byte valid in the end cycle counts toward the 8.
- R6: An `usb_end` that closes a reception after any count other than 8 sets `pkt_err` and leaves `setup_rcvd` at 0. Bytes past the eighth are discarded.
- R7: `rd_invalid` is set when `usb_start` arrives while the read position is not 0. It is also set when `cpu_rd` is high during a reception or in a start cycle. It stays set until cleared.
- R8: `cpu_clr_inv` clears `rd_invalid`, except in a cycle where a set condition of R7 also holds.
- R9: `cpu_ack` clears `setup_rcvd`, except in a cycle where R5 sets it.
- R10: `usb_valid` and `usb_end` outside a reception change neither the storage nor any flag.
- R11: A synchronous active-high `rst` clears the read position, the write count, the storage, `cpu_rdata` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_start | input | 1 | Opens a setup reception |
| usb_valid | input | 1 | `usb_data` carries a byte this cycle |
| usb_data | input | 8 | Received byte |
| usb_end | input | 1 | Closes the reception |
| cpu_rd | input | 1 | CPU read strobe, one byte per pulse |
| cpu_clr_inv | input | 1 | Write-one clear of `rd_invalid` |
| cpu_ack | input | 1 | Acknowledge, clears `setup_rcvd` |
| cpu_rdata | output | 8 | Byte returned by the last read |
| setup_rcvd | output | 1 | A complete 8-byte packet is held |
| pkt_err | output | 1 | The last reception had the wrong length |
| rd_invalid | output | 1 | A CPU read overlapped a reception |

## Verification
The assertions take for granted that `usb_start` and `usb_end` never pulse in the same cycle. The packet-length property further relies on an end strobe only ever being seen after a start. The reference-model bench drives strobes from a small random generator that keeps `usb_end` low whenever it raises `usb_start`. CPU strobes are left unconstrained, so they may overlap receptions in any way. Directed sequences cover short and long packets, overlapping reads, same-cycle set and clear, and strobes outside a reception.

// File: rtl/setup_buf_pkg.sv
package setup_buf_pkg;
    parameter int BYTES  = 8;
    parameter int DATA_W = 8;
    localparam int IDX_W = $clog2(BYTES);
    localparam int CNT_W = $clog2(BYTES + 2);

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // closing event of a reception
    typedef struct packed {
        logic good;
        logic bad;
    } rx_close_t;

    function automatic idx_t idx_step(idx_t cur);
        if (int'(cur) == BYTES - 1) return '0;
        return cur + 1'b1;
    endfunction
endpackage

// File: rtl/setup_store.sv
module setup_store
    import setup_buf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      usb_start,
    input  logic      usb_valid,
    input  byte_t     usb_data,
    input  logic      usb_end,
    input  idx_t      rd_idx,
    output byte_t     rd_byte,
    output logic      receiving,
    output rx_close_t rx_close
);
    logic  rx_q;
    cnt_t  count_q, count_next;
    byte_t slot_q [BYTES];
    logic  accept;

    assign accept = rx_q && !usb_start && usb_valid;

    always_comb begin
        count_next = count_q;
        if (accept && count_q < cnt_t'(BYTES + 1))
            count_next = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= 1'b0;
            count_q <= '0;
        end else if (usb_start) begin
            rx_q    <= 1'b1;
            count_q <= '0;
        end else if (rx_q) begin
            count_q <= count_next;
            if (usb_end) rx_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (accept && count_q == cnt_t'(g))
                slot_q[g] <= usb_data;
        end
    end

    assign rd_byte        = slot_q[rd_idx];
    assign receiving      = rx_q;
    assign rx_close.good  = rx_q && !usb_start && usb_end && count_next == cnt_t'(BYTES);
    assign rx_close.bad   = rx_q && !usb_start && usb_end && count_next != cnt_t'(BYTES);

    // R6
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= cnt_t'(BYTES + 1));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_q && !usb_start) |=> $stable(count_q) && !rx_q);
endmodule

// File: rtl/setup_read_port.sv
module setup_read_port
    import setup_buf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_rd,
    input  byte_t rd_byte,
    output idx_t  rd_idx,
    output byte_t cpu_rdata
);
    idx_t  idx_q;
    byte_t data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            data_q <= '0;
        end else if (cpu_rd) begin
            idx_q  <= idx_step(idx_q);
            data_q <= rd_byte;
        end
    end

    assign rd_idx    = idx_q;
    assign cpu_rdata = data_q;

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && idx_q == '0) |=> idx_q == idx_t'(1));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(idx_q) && $stable(data_q));
endmodule

// File: rtl/setup_flags.sv
module setup_flags
    import setup_buf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      usb_start,
    input  logic      receiving,
    input  rx_close_t rx_close,
    input  logic      cpu_rd,
    input  logic      rd_mid,
    input  logic      cpu_clr_inv,
    input  logic      cpu_ack,
    output logic      setup_rcvd,
    output logic      pkt_err,
    output logic      rd_invalid
);
    logic rcvd_q, err_q, inv_q, inv_set;

    assign inv_set = (usb_start && rd_mid) || (cpu_rd && (receiving || usb_start));

    always_ff @(posedge clk) begin
        if (rst) begin
            rcvd_q <= 1'b0;
            err_q  <= 1'b0;
            inv_q  <= 1'b0;
        end else begin
            if (inv_set)          inv_q <= 1'b1;
            else if (cpu_clr_inv) inv_q <= 1'b0;

            if (usb_start) begin
                rcvd_q <= 1'b0;
                err_q  <= 1'b0;
            end else if (rx_close.good) begin
                rcvd_q <= 1'b1;
                err_q  <= 1'b0;
            end else if (rx_close.bad) begin
                err_q  <= 1'b1;
            end else if (cpu_ack) begin
                rcvd_q <= 1'b0;
            end
        end
    end

    assign setup_rcvd = rcvd_q;
    assign pkt_err    = err_q;
    assign rd_invalid = inv_q;

    // R5
    rcvd_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rcvd_q) |-> $past(rx_close.good));

    // R6
    rcvd_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rcvd_q && err_q));

    // R7
    inv_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inv_q) |-> $past(usb_start || cpu_rd));

    // R8
    inv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_q && !cpu_clr_inv) |=> inv_q);
endmodule

// File: rtl/setup_pkt_buf.sv
module setup_pkt_buf
    import setup_buf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        usb_start,
    input  logic        usb_valid,
    input  logic [7:0]  usb_data,
    input  logic        usb_end,
    input  logic        cpu_rd,
    input  logic        cpu_clr_inv,
    input  logic        cpu_ack,
    output logic [7:0]  cpu_rdata,
    output logic        setup_rcvd,
    output logic        pkt_err,
    output logic        rd_invalid
);
    idx_t      rd_idx;
    byte_t     rd_byte;
    logic      receiving;
    rx_close_t rx_close;

    setup_store u_store (
        .clk       (clk),
        .rst       (rst),
        .usb_start (usb_start),
        .usb_valid (usb_valid),
        .usb_data  (usb_data),
        .usb_end   (usb_end),
        .rd_idx    (rd_idx),
        .rd_byte   (rd_byte),
        .receiving (receiving),
        .rx_close  (rx_close)
    );

    setup_read_port u_read (
        .clk       (clk),
        .rst       (rst),
        .cpu_rd    (cpu_rd),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .cpu_rdata (cpu_rdata)
    );

    setup_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .usb_start   (usb_start),
        .receiving   (receiving),
        .rx_close    (rx_close),
        .cpu_rd      (cpu_rd),
        .rd_mid      (rd_idx != '0),
        .cpu_clr_inv (cpu_clr_inv),
        .cpu_ack     (cpu_ack),
        .setup_rcvd  (setup_rcvd),
        .pkt_err     (pkt_err),
        .rd_invalid  (rd_invalid)
    );

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(usb_start && usb_end));

    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        usb_start |=> !setup_rcvd && !pkt_err);
endmodule

// File: tb/setup_pkt_buf_test.sv
`timescale 1ns/1ps
module setup_pkt_buf_test;
    logic clk = 0, rst = 1;
    logic usb_start = 0, usb_valid = 0, usb_end = 0;
    logic [7:0] usb_data = 0;
    logic cpu_rd = 0, cpu_clr_inv = 0, cpu_ack = 0;
    logic [7:0] cpu_rdata;
    logic setup_rcvd, pkt_err, rd_invalid;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_mem [8];
    int  m_cnt = 0, m_rp = 0;
    bit  m_rx = 0, m_rcvd = 0, m_err = 0, m_inv = 0;
    logic [7:0] m_rd = 0;

    always #4 clk = ~clk;

    setup_pkt_buf uut (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit set_inv;
        int ncnt;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_cnt = 0; m_rp = 0; m_rx = 0; m_rcvd = 0; m_err = 0; m_inv = 0; m_rd = 0;
            return;
        end
        set_inv = (usb_start && m_rp != 0) || (cpu_rd && (m_rx || usb_start));
        if (cpu_rd) begin
            m_rd = m_mem[m_rp];
            m_rp = (m_rp + 1) % 8;
        end
        if (set_inv) m_inv = 1; else if (cpu_clr_inv) m_inv = 0;
        if (usb_start) begin
            m_rx = 1; m_cnt = 0; m_rcvd = 0; m_err = 0;
        end else if (m_rx) begin
            ncnt = m_cnt;
            if (usb_valid) begin
                if (m_cnt < 8) m_mem[m_cnt] = usb_data;
                if (m_cnt < 9) ncnt = m_cnt + 1;
            end
            m_cnt = ncnt;
            if (usb_end) begin
                m_rx = 0;
                if (ncnt == 8) begin m_rcvd = 1; m_err = 0; end
                else m_err = 1;
            end else if (cpu_ack) m_rcvd = 0;
        end else if (cpu_ack) m_rcvd = 0;
    endtask

    // one clock: model follows the edge, outputs compared 2 ns later
    task automatic cyc();
        @(posedge clk);
        model_step();
        #2;
        chk(cpu_rdata == m_rd, "R2 rdata", cpu_rdata, m_rd);
        chk(setup_rcvd == m_rcvd, "R5 setup_rcvd", setup_rcvd, m_rcvd);
        chk(pkt_err == m_err, "R6 pkt_err", pkt_err, m_err);
        chk(rd_invalid == m_inv, "R7 rd_invalid", rd_invalid, m_inv);
    endtask

    task automatic idle();
        usb_start = 0; usb_valid = 0; usb_end = 0;
        cpu_rd = 0; cpu_clr_inv = 0; cpu_ack = 0;
    endtask

    task automatic send_pkt(int n, logic [7:0] base);
        usb_start = 1; cyc(); idle();
        for (int i = 0; i < n; i++) begin
            usb_valid = 1; usb_data = base + 8'(i); cyc(); idle();
        end
        usb_end = 1; cyc(); idle();
    endtask

    task automatic read_chk(int n, logic [7:0] first, string req);
        for (int i = 0; i < n; i++) begin
            cpu_rd = 1; cyc(); idle();
            chk(cpu_rdata == first + 8'(i), req, cpu_rdata, first + 8'(i));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; cyc(); cyc();
        rst = 0;
        // R11 reset state
        chk({cpu_rdata, setup_rcvd, pkt_err, rd_invalid} == 0, "R11 reset", cpu_rdata, 0);

        // R1 R5 good packet, read back in order
        send_pkt(8, 8'h10);
        chk(setup_rcvd == 1 && pkt_err == 0, "R5 good end", setup_rcvd, 1);
        read_chk(8, 8'h10, "R1 order");
        // R9 ack clears
        cpu_ack = 1; cyc(); idle();
        chk(setup_rcvd == 0, "R9 ack", setup_rcvd, 0);

        // R9 ack in the same cycle as a good end: set wins
        usb_start = 1; cyc(); idle();
        for (int i = 0; i < 8; i++) begin usb_valid = 1; usb_data = 8'h30 + 8'(i); cyc(); idle(); end
        usb_end = 1; cpu_ack = 1; cyc(); idle();
        chk(setup_rcvd == 1, "R9 set wins", setup_rcvd, 1);
        read_chk(8, 8'h30, "R1 order 2");

        // R6 short packet
        send_pkt(5, 8'h20);
        chk(pkt_err == 1 && setup_rcvd == 0, "R6 short", pkt_err, 1);
        read_chk(5, 8'h20, "R6 short bytes");
        read_chk(3, 8'h35, "R6 old tail kept");

        // R6 long packet, extra bytes dropped; R4 start clears err
        send_pkt(10, 8'h40);
        chk(pkt_err == 1 && setup_rcvd == 0, "R6 long", pkt_err, 1);
        read_chk(8, 8'h40, "R6 long bytes");

        // R2 R7 misaligned read after partial sequence
        send_pkt(8, 8'h50);
        chk(pkt_err == 0, "R4 err cleared", pkt_err, 0);
        read_chk(3, 8'h50, "R2 partial");
        send_pkt(8, 8'h60);
        chk(rd_invalid == 1, "R7 start mid-read", rd_invalid, 1);
        read_chk(5, 8'h63, "R2 no realign");
        read_chk(1, 8'h60, "R2 wrap");

        // R8 clear
        cpu_clr_inv = 1; cyc(); idle();
        chk(rd_invalid == 0, "R8 clear", rd_invalid, 0);
        // R8 clear with a set in the same cycle (read position is 1)
        usb_start = 1; cpu_clr_inv = 1; cyc(); idle();
        chk(rd_invalid == 1, "R8 set wins", rd_invalid, 1);
        for (int i = 0; i < 8; i++) begin usb_valid = 1; usb_data = 8'h70 + 8'(i); cyc(); idle(); end
        usb_end = 1; cyc(); idle();
        cpu_clr_inv = 1; cyc(); idle();
        read_chk(7, 8'h71, "R2 realign");

        // R3 R7 read colliding with a write of the same slot
        usb_start = 1; cyc(); idle();
        usb_valid = 1; usb_data = 8'h80; cpu_rd = 1; cyc(); idle();
        chk(cpu_rdata == 8'h70, "R3 old data", cpu_rdata, 8'h70);
        chk(rd_invalid == 1, "R7 read in reception", rd_invalid, 1);
        for (int i = 1; i < 8; i++) begin usb_valid = 1; usb_data = 8'h80 + 8'(i); cyc(); idle(); end
        usb_end = 1; cyc(); idle();
        chk(setup_rcvd == 1, "R3 write kept", setup_rcvd, 1);

        // R10 strobes outside a reception
        for (int i = 0; i < 4; i++) begin usb_valid = 1; usb_data = 8'hEE; cyc(); idle(); end
        usb_end = 1; cyc(); idle();
        chk(setup_rcvd == 1 && pkt_err == 0, "R10 flags kept", setup_rcvd, 1);
        read_chk(7, 8'h81, "R10 storage kept");

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            usb_start   = ($urandom % 16) == 0;
            usb_end     = !usb_start && (($urandom % 10) == 0);
            usb_valid   = ($urandom % 3) != 0;
            usb_data    = 8'($urandom);
            cpu_rd      = ($urandom % 4) == 0;
            cpu_clr_inv = ($urandom % 8) == 0;
            cpu_ack     = ($urandom % 8) == 0;
            cyc();
        end
        idle();
        rst = 1; cyc(); rst = 0;
        chk({cpu_rdata, setup_rcvd, pkt_err, rd_invalid} == 0, "R11 late reset", cpu_rdata, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule